// File: doc/BRIEF.md
# Programmable Decade Delay Controller

This block is the digital core of a long-period timer. An external free-running oscillator is seen as a one-clock tick pulse on a system clock. The block counts those ticks through a chain of up to six decade stages, so the oscillator period is multiplied by 10, 100 and so on up to one million. A captured configuration byte picks the multiplier and the operating mode.

In one-shot mode a falling edge on the active-low trigger raises the output, starts the oscillator and clears the chain. The output drops again after exactly the selected number of ticks. In square-wave mode the oscillator runs while the trigger is held low, and the output is the tick rate divided by the multiplier, with equal high and low phases. When the multiplier code selects a factor of one, the chain is skipped and the output is a toggle flop driven straight by the ticks, as a plain analog timer would behave. An active-low reset clears the output asynchronously.

Top module: `decade_delay_ctrl`

## Requirements
- R1: Configuration bits [2:0] set the multiplier N: 001=10, 010=100, 011=1000, 100=10^4, 101=10^5, 110=10^6; with bit 3 = 1 the output pulse then lasts exactly N oscillator ticks, and `bypassMode` reads 0.
- R2: Codes 000 and 111 in bits [2:0] select bypass: `bypassMode` = 1, `oscEnable` = 1 while reset is high, and `timerOut` toggles once per tick, so every high and every low phase spans exactly one tick.
- R3: Bit 3 picks square-wave (0) or one-shot (1) when the chain is in use, and has no effect in bypass: code 111 with bit 3 = 1 still gives one-tick phases.
- R4: In one-shot mode, a falling trigger edge is seen through a two-flop synchronizer; `timerOut` and `oscEnable` rise on the third rising clock edge after the trigger is driven low (still low after the second), and the chain starts from zero.
- R5: A one-shot ends when the selected terminal count is reached: `timerOut` and `oscEnable` are low in the cycle after the N-th counted tick.
- R6: In square-wave mode `oscEnable` is high only while reset is high and the synchronized trigger is low; while it is low the chain is held at zero and `timerOut` is 0.
- R7: In square-wave mode every high phase and every low phase of `timerOut` spans exactly N/2 ticks, the first low phase counting from the start of `oscEnable`.
- R8: Driving `rstN` low forces `timerOut` and `oscEnable` to 0 without a clock edge, and after release no output pulse follows unless a new trigger edge arrives.
- R9: `cfgView` shows the captured configuration with bit 7 always 1; during reset it holds 0x80, which selects bypass.
- R10: Bits 4 and 5 of the configuration appear unchanged on `cfgView[5:4]` and do not change the pulse length.
- R11: A trigger edge during an active one-shot is ignored, and a trigger that stays low after the terminal count starts no new pulse.
- R12: The configuration is captured only while the block is idle (no one-shot running, no square wave enabled); a change during a cycle neither alters `cfgView` nor the pulse length until the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oscTick | input | 1 | One-cycle pulse per oscillator period |
| trigN | input | 1 | Trigger, active low, asynchronous to clk |
| cfgByte | input | 8 | Configuration byte to be captured |
| timerOut | output | 1 | Timer output |
| oscEnable | output | 1 | Oscillator run enable |
| bypassMode | output | 1 | High when the decade chain is skipped |
| cfgView | output | 8 | Captured configuration, bit 7 forced to 1 |

## Verification
The one-shot is started at multipliers 10, 100 and 1000 and its width is measured in counted ticks, which separates a correct terminal-count pick from a neighbouring decade and from an off-by-one end. Square-wave runs at 10 and 100 measure each phase separately, so an uneven split between the divide-by-5 and divide-by-2 parts shows up as unequal phases. Bypass is tried with both factor-of-one codes and with the mode bit set, telling a real bypass from a chain that merely runs short. Retriggering, a configuration change and a reset in mid-pulse show whether the cycle is protected from late inputs and abandoned on reset.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;      // zero the whole decade chain
    logic countEn;    // one gated tick into the first decade
    logic oscToggle;  // flip the bypass oscillator flop
    logic oscClear;   // hold the bypass oscillator flop at zero
  } ddcStrobe_t;

  typedef enum logic [1:0] {
    MODE_BYPASS  = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_SQUARE  = 2'd2
  } ddcMode_t;

  localparam logic [7:0] CFG_RESET_VALUE = 8'h80;

endpackage

// File: rtl/ddc_config.sv
module ddc_config
  import ddc_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int CODE_W      = 3,
  parameter int NUM_DECADES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  cfgByte,
  input  logic              busy,
  output logic [CFG_W-1:0]  cfgView,
  output logic [CODE_W-1:0] code,
  output ddcMode_t          mode
);

  localparam logic [CFG_W-1:0] MSB_ONE = CFG_W'(1) << (CFG_W - 1);

  logic [CFG_W-1:0] cfgReg;
  logic             isBypass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= CFG_W'(CFG_RESET_VALUE);
    end else if (!busy) begin
      cfgReg <= cfgByte | MSB_ONE;
    end
  end

  assign cfgView  = cfgReg;
  assign code     = cfgReg[CODE_W-1:0];
  assign isBypass = (code == '0) || (int'(code) > NUM_DECADES);

  always_comb begin
    if (isBypass) begin
      mode = MODE_BYPASS;
    end else if (cfgReg[CODE_W]) begin
      mode = MODE_ONESHOT;
    end else begin
      mode = MODE_SQUARE;
    end
  end

  // R12: configuration must not move while a cycle is in progress
  a_r12_frozen_while_busy: assert property (
    @(posedge clk) disable iff (!rstN) busy |=> $stable(cfgReg)
  );

endmodule

// File: rtl/ddc_decade.sv
module ddc_decade #(
  parameter int LOW_DIV = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic en,
  output logic tog,
  output logic carry
);

  localparam int CNT_W = $clog2(LOW_DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOW_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (en) begin
      if (cnt == LAST) begin
        cnt <= '0;
        tog <= ~tog;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // one carry per full decade: last count of the high half
  assign carry = en & tog & (cnt == LAST);

endmodule

// File: rtl/ddc_datapath.sv
module ddc_datapath
  import ddc_pkg::*;
#(
  parameter int NUM_DECADES = 6,
  parameter int CODE_W      = 3,
  parameter int LOW_DIV     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ddcStrobe_t        strobe,
  input  logic [CODE_W-1:0] code,
  output logic              divOut,
  output logic              tcHit,
  output logic              oscLevel
);

  logic [NUM_DECADES-1:0] tog;
  logic [NUM_DECADES-1:0] carry;

  for (genvar g = 0; g < NUM_DECADES; g++) begin : g_stage
    logic stageEn;
    if (g == 0) begin : g_first
      assign stageEn = strobe.countEn;
    end else begin : g_next
      assign stageEn = carry[g-1];
    end

    ddc_decade #(.LOW_DIV(LOW_DIV)) u_decade (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (strobe.clear),
      .en    (stageEn),
      .tog   (tog[g]),
      .carry (carry[g])
    );

    // R7: a full decade wraps with its half-period flop returning low
    a_r7_carry_drops_half: assert property (
      @(posedge clk) disable iff (!rstN) carry[g] |=> !tog[g]
    );
  end

  // code k picks decade k-1 for both output and terminal count
  always_comb begin
    divOut = 1'b0;
    tcHit  = 1'b0;
    for (int i = 0; i < NUM_DECADES; i++) begin
      if (code == CODE_W'(i + 1)) begin
        divOut = tog[i];
        tcHit  = carry[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscLevel <= 1'b0;
    end else if (strobe.oscClear) begin
      oscLevel <= 1'b0;
    end else if (strobe.oscToggle) begin
      oscLevel <= ~oscLevel;
    end
  end

  // R6: a clear leaves every half-period flop low
  a_r6_clear_zeroes_chain: assert property (
    @(posedge clk) disable iff (!rstN) strobe.clear |=> (tog == '0)
  );

endmodule

// File: rtl/ddc_control.sv
module ddc_control
  import ddc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigN,
  input  logic       oscTick,
  input  ddcMode_t   mode,
  input  logic       tcHit,
  input  logic       divOut,
  input  logic       oscLevel,
  output ddcStrobe_t strobe,
  output logic       timerOut,
  output logic       oscEnable,
  output logic       busy
);

  logic trigS1, trigS2, trigPrev;
  logic monoRun;
  logic fallSeen, startShot, tickGated, runGate;
  logic isBypass, isShot, isSquare;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigS1   <= 1'b1;
      trigS2   <= 1'b1;
      trigPrev <= 1'b1;
    end else begin
      trigS1   <= trigN;
      trigS2   <= trigS1;
      trigPrev <= trigS2;
    end
  end

  assign isBypass  = (mode == MODE_BYPASS);
  assign isShot    = (mode == MODE_ONESHOT);
  assign isSquare  = (mode == MODE_SQUARE);
  assign fallSeen  = trigPrev & ~trigS2;
  assign startShot = isShot & ~monoRun & fallSeen;

  always_comb begin
    unique case (mode)
      MODE_BYPASS:  runGate = 1'b1;
      MODE_ONESHOT: runGate = monoRun;
      MODE_SQUARE:  runGate = ~trigS2;
      default:      runGate = 1'b0;
    endcase
  end

  assign oscEnable = rstN & runGate;
  assign tickGated = oscTick & oscEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monoRun <= 1'b0;
    end else if (!isShot) begin
      monoRun <= 1'b0;
    end else if (startShot) begin
      monoRun <= 1'b1;
    end else if (monoRun && tcHit) begin
      monoRun <= 1'b0;
    end
  end

  always_comb begin
    strobe.clear     = startShot | (isSquare & ~oscEnable);
    strobe.countEn   = ~isBypass & tickGated;
    strobe.oscToggle = isBypass & tickGated;
    strobe.oscClear  = ~isBypass;
  end

  always_comb begin
    unique case (mode)
      MODE_BYPASS:  timerOut = oscLevel;
      MODE_ONESHOT: timerOut = monoRun;
      MODE_SQUARE:  timerOut = divOut;
      default:      timerOut = 1'b0;
    endcase
  end

  assign busy = monoRun | (isSquare & ~trigS2);

  // R4: the start edge raises output and oscillator enable next cycle
  a_r4_start_raises_out: assert property (
    @(posedge clk) disable iff (!rstN) startShot |=> (timerOut && oscEnable)
  );

  // R5: terminal count ends the pulse
  a_r5_terminal_ends_pulse: assert property (
    @(posedge clk) disable iff (!rstN)
      (isShot && monoRun && tcHit) |=> (!timerOut && !oscEnable)
  );

  // R11: a new edge inside a running pulse does not disturb it
  a_r11_retrigger_ignored: assert property (
    @(posedge clk) disable iff (!rstN)
      (monoRun && fallSeen && !tcHit) |=> monoRun
  );

endmodule

// File: rtl/decade_delay_ctrl.sv
module decade_delay_ctrl
  import ddc_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int CODE_W      = 3,
  parameter int NUM_DECADES = 6,
  parameter int LOW_DIV     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic             trigN,
  input  logic [CFG_W-1:0] cfgByte,
  output logic             timerOut,
  output logic             oscEnable,
  output logic             bypassMode,
  output logic [CFG_W-1:0] cfgView
);

  ddcStrobe_t        strobe;
  ddcMode_t          mode;
  logic [CODE_W-1:0] code;
  logic              busy, divOut, tcHit, oscLevel;

  ddc_config #(
    .CFG_W(CFG_W), .CODE_W(CODE_W), .NUM_DECADES(NUM_DECADES)
  ) u_config (
    .clk     (clk),
    .rstN    (rstN),
    .cfgByte (cfgByte),
    .busy    (busy),
    .cfgView (cfgView),
    .code    (code),
    .mode    (mode)
  );

  ddc_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .trigN     (trigN),
    .oscTick   (oscTick),
    .mode      (mode),
    .tcHit     (tcHit),
    .divOut    (divOut),
    .oscLevel  (oscLevel),
    .strobe    (strobe),
    .timerOut  (timerOut),
    .oscEnable (oscEnable),
    .busy      (busy)
  );

  ddc_datapath #(
    .NUM_DECADES(NUM_DECADES), .CODE_W(CODE_W), .LOW_DIV(LOW_DIV)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .code     (code),
    .divOut   (divOut),
    .tcHit    (tcHit),
    .oscLevel (oscLevel)
  );

  assign bypassMode = (mode == MODE_BYPASS);

endmodule

// File: tb/decade_delay_ctrl_bench.sv
module decade_delay_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscTick = 1'b0;
  logic       trigN = 1'b1;
  logic [7:0] cfgByte = 8'h80;
  logic       timerOut, oscEnable, bypassMode;
  logic [7:0] cfgView;

  decade_delay_ctrl u_decade_delay_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .trigN(trigN),
    .cfgByte(cfgByte), .timerOut(timerOut), .oscEnable(oscEnable),
    .bypassMode(bypassMode), .cfgView(cfgView)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    level;   // -1: either level
    int    width;   // ticks counted in the phase
    string req;
  } phase_t;

  phase_t expQ[$];
  int     checks = 0;
  int     errors = 0;
  bit     monClear = 0;
  bit     finished = 0;
  int     tickCnt = 0;
  logic   prevLevel;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // oscillator ticks: one clock high out of every three
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1;
      oscTick = (ph == 2);
      ph = (ph + 1) % 3;
    end
  end

  // monitor: measure each output phase in enabled ticks, compare to queue
  always @(negedge clk) begin
    phase_t it;
    if (monClear) begin
      tickCnt   = 0;
      prevLevel = timerOut;
      monClear  = 0;
    end else if (timerOut !== prevLevel) begin
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        check((it.level < 0 || it.level == int'(prevLevel)) && it.width == tickCnt,
              it.req, tickCnt, it.width);
      end
      tickCnt   = 0;
      prevLevel = timerOut;
    end
    if (oscTick && oscEnable) tickCnt++;
  end

  task automatic clocks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(int lv, int w, string r);
    phase_t it;
    it.level = lv;
    it.width = w;
    it.req   = r;
    expQ.push_back(it);
  endtask

  task automatic drain(int maxClk, string r);
    int k = 0;
    while (expQ.size() > 0 && k < maxClk) begin
      clocks(1);
      k++;
    end
    check(expQ.size() == 0, r, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic startClear();
    monClear = 1;
    clocks(2);
  endtask

  task automatic runShot(logic [7:0] cfg, int n, string r);
    cfgByte = cfg;
    trigN   = 1'b1;
    clocks(6);
    startClear();
    push(0, 0, r);
    push(1, n, r);
    trigN = 1'b0;
    drain(3 * n + 60, r);
    clocks(1);
    check(oscEnable == 1'b0, "R5", oscEnable, 0);
    check(timerOut == 1'b0, "R5", timerOut, 0);
    trigN = 1'b1;
    clocks(6);
  endtask

  initial begin
    // reset state
    clocks(3);
    check(timerOut == 1'b0, "R8", timerOut, 0);
    check(oscEnable == 1'b0, "R8", oscEnable, 0);
    check(cfgView == 8'h80, "R9", cfgView, 8'h80);
    check(bypassMode == 1'b1, "R9", bypassMode, 1);
    rstN = 1'b1;
    clocks(3);
    check(oscEnable == 1'b1, "R2", oscEnable, 1);

    // bypass, code 000, bit 7 forced
    cfgByte = 8'h00;
    clocks(3);
    check(cfgView == 8'h80, "R9", cfgView, 8'h80);
    check(bypassMode == 1'b1, "R2", bypassMode, 1);
    startClear();
    for (int i = 0; i < 4; i++) push(-1, 1, "R2");
    drain(100, "R2");

    // bypass, code 111 with one-shot bit set
    cfgByte = 8'h0F;
    clocks(3);
    check(bypassMode == 1'b1, "R3", bypassMode, 1);
    check(cfgView == 8'h8F, "R3", cfgView, 8'h8F);
    startClear();
    for (int i = 0; i < 4; i++) push(-1, 1, "R3");
    drain(100, "R3");

    // one-shot widths
    runShot(8'h89, 10, "R1");
    check(bypassMode == 1'b0, "R1", bypassMode, 0);
    runShot(8'h8A, 100, "R5");
    runShot(8'h8B, 1000, "R1");

    // start latency through the synchronizer
    cfgByte = 8'h89;
    trigN = 1'b1;
    clocks(6);
    startClear();
    push(0, 0, "R4");
    push(1, 10, "R4");
    trigN = 1'b0;
    clocks(2);
    check(timerOut == 1'b0, "R4", timerOut, 0);
    clocks(1);
    check(timerOut == 1'b1, "R4", timerOut, 1);
    check(oscEnable == 1'b1, "R4", oscEnable, 1);
    drain(100, "R4");
    trigN = 1'b1;
    clocks(6);

    // bits 4 and 5 pass through, no timing effect
    runShot(8'hB9, 10, "R10");
    check(cfgView[5:4] == 2'b11, "R10", cfgView[5:4], 3);

    // retrigger inside a pulse, and trigger held low after it
    cfgByte = 8'h8A;
    trigN = 1'b1;
    clocks(6);
    startClear();
    push(0, 0, "R11");
    push(1, 100, "R11");
    trigN = 1'b0;
    clocks(60);
    trigN = 1'b1;
    clocks(6);
    trigN = 1'b0;
    drain(400, "R11");
    clocks(300);
    check(timerOut == 1'b0, "R11", timerOut, 0);
    trigN = 1'b1;
    clocks(6);

    // configuration change during a pulse
    cfgByte = 8'h89;
    clocks(6);
    startClear();
    push(0, 0, "R12");
    push(1, 10, "R12");
    trigN = 1'b0;
    clocks(12);
    cfgByte = 8'h8A;
    clocks(3);
    check(cfgView == 8'h89, "R12", cfgView, 8'h89);
    drain(100, "R12");
    clocks(3);
    check(cfgView == 8'h8A, "R12", cfgView, 8'h8A);
    trigN = 1'b1;
    clocks(6);

    // square wave, divide by 10
    cfgByte = 8'h01;
    clocks(6);
    check(oscEnable == 1'b0, "R6", oscEnable, 0);
    check(timerOut == 1'b0, "R6", timerOut, 0);
    startClear();
    push(0, 5, "R7");
    push(1, 5, "R7");
    push(0, 5, "R7");
    push(1, 5, "R7");
    trigN = 1'b0;
    clocks(3);
    check(oscEnable == 1'b1, "R6", oscEnable, 1);
    drain(200, "R7");
    trigN = 1'b1;
    clocks(6);
    check(oscEnable == 1'b0, "R6", oscEnable, 0);
    check(timerOut == 1'b0, "R6", timerOut, 0);

    // square wave, divide by 100
    cfgByte = 8'h02;
    clocks(6);
    startClear();
    push(0, 50, "R7");
    push(1, 50, "R7");
    push(0, 50, "R7");
    push(1, 50, "R7");
    trigN = 1'b0;
    drain(800, "R7");
    trigN = 1'b1;
    clocks(6);

    // reset in mid-pulse
    cfgByte = 8'h8B;
    clocks(6);
    trigN = 1'b0;
    clocks(100);
    check(timerOut == 1'b1, "R8", timerOut, 1);
    rstN = 1'b0;
    #2;
    check(timerOut == 1'b0, "R8", timerOut, 0);
    check(oscEnable == 1'b0, "R8", oscEnable, 0);
    trigN = 1'b1;
    clocks(2);
    rstN = 1'b1;
    clocks(300);
    check(timerOut == 1'b0, "R8", timerOut, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule